// File: doc/BRIEF.md
# Processor Mailbox and Signal Unit

This unit carries short control messages between one compute element and the agents outside it. The local processor sees blocking channels. It posts 32-bit words into two outbound mailboxes, and one of these also drives an interrupt line toward the outside. It takes words from a four-entry inbound queue. It collects notification words from a set of signal registers. Each processor-side channel uses a valid/ready handshake. A write to a full mailbox, or a read from an empty queue or a zero signal register, simply waits until the other side acts.

Outside agents reach the unit through a plain word-addressed register port with a read strobe and a write strobe. Reading a mailbox address removes its entry. Writing the queue address appends a word. Writing a signal address loads that register. A status word reports how full each mailbox is. It also carries a sticky flag that records a dropped inbound write.

Top module: `msgport_unit`

## Requirements
- R1: The outbound mailbox holds OUT_DEPTH (default 1) words. While it is full, `out_ready_o` is low and a processor write waits. A register read at word address 1 returns the oldest word and removes it. A read of an empty mailbox returns 0 and changes nothing.
- R2: The interrupt mailbox behaves like R1 at word address 2, with the processor writing through `irqbox_*`. `irq_o` is high from the cycle after a word is accepted and stays high while the mailbox holds a word. It drops the cycle after the last word is read out.
- R3: A register write at word address 3 appends a word to the inbound queue, which holds IN_DEPTH (default 4) words. The processor receives the words oldest first through `in_valid_o`/`in_ready_i`. `in_valid_o` stays low while the queue is empty, so a processor read waits.
- R4: A write at address 3 while the queue holds IN_DEPTH words is dropped, even if the processor takes a word in the same cycle. The drop sets the overflow flag at status bit 31. The flag stays set until a register write at address 0 with bit 31 set.
- R5: Signal register i is loaded by a register write at word address 4+i, and the write replaces its value. While the value is nonzero, `sig_valid_o[i]` is high. A processor take returns the value on `sig_data_o[32*i +: 32]` and clears the register to zero. While the value is zero the take waits.
- R6: When a register write and a processor take hit the same signal register in the same cycle, the register holds the written value afterwards.
- R7: A read at word address 0 returns the status word: bits 7:0 the outbound count, bits 15:8 the interrupt-mailbox count, bits 23:16 the inbound count, bit 31 the overflow flag, and all other bits 0. A read of any other address except 1 and 2 returns 0.
- R8: After reset all mailboxes are empty, all signal registers are zero, `irq_o` and every `*_valid_o` output are low, the ready outputs are high, and the status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_valid_i | input | 1 | Processor offers a word to the outbound mailbox |
| out_data_i | input | DATA_W | Outbound word |
| out_ready_o | output | 1 | Outbound mailbox has room |
| irqbox_valid_i | input | 1 | Processor offers a word to the interrupt mailbox |
| irqbox_data_i | input | DATA_W | Interrupt-mailbox word |
| irqbox_ready_o | output | 1 | Interrupt mailbox has room |
| in_valid_o | output | 1 | Inbound queue holds a word |
| in_data_o | output | DATA_W | Oldest inbound word |
| in_ready_i | input | 1 | Processor takes the inbound word |
| sig_take_i | input | NSIG | Processor takes signal register i |
| sig_valid_o | output | NSIG | Signal register i is nonzero |
| sig_data_o | output | NSIG*DATA_W | Signal register values, register i in slice i |
| mm_wr_i | input | 1 | Register write strobe |
| mm_rd_i | input | 1 | Register read strobe |
| mm_addr_i | input | ADDR_W | Word address |
| mm_wdata_i | input | DATA_W | Register write data |
| mm_rdata_o | output | DATA_W | Register read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt toward the outside agent |

## Verification
The assertions assume that the outside agent never raises the read and write strobes in the same cycle, and a separate property checks that assumption. They also assume that the processor holds its valid and data steady until the handshake completes. The bench drives every register access as a single-cycle strobe of one kind. It keeps each processor offer raised and unchanged until ready is seen. Random traffic only offers a word when the model says there is room. Stalls are tested with directed sequences in which the opposite side completes the transfer later.

// File: rtl/msgu_pkg.sv
package msgu_pkg;
   localparam int unsigned ADR_STATUS   = 0;
   localparam int unsigned ADR_OUT_POP  = 1;
   localparam int unsigned ADR_IRQ_POP  = 2;
   localparam int unsigned ADR_IN_PUSH  = 3;
   localparam int unsigned ADR_SIG_BASE = 4;
   localparam int unsigned STAT_OVF_BIT = 31;
   localparam int unsigned STAT_FIELD_W = 8;
   localparam int unsigned MAX_DEPTH    = 127;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned CW   = $clog2(DEPTH + 1),
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);
   if (DEPTH < 1 || DEPTH > msgu_pkg::MAX_DEPTH) begin : g_bad_depth
      $error("mbox_fifo: DEPTH out of range");
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] hold_q;
      logic         full_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            full_q <= 1'b0;
            hold_q <= '0;
         end else if (push && !full_q) begin
            full_q <= 1'b1;
            hold_q <= push_data;
         end else if (pop && full_q) begin
            full_q <= 1'b0;
         end
      end
      assign head  = hold_q;
      assign full  = full_q;
      assign empty = !full_q;
      assign count = CW'(full_q);
   end else begin : g_ring
      logic [W-1:0]  mem [DEPTH];
      logic [PW-1:0] wp_q, rp_q;
      logic [CW-1:0] cnt_q;
      logic          do_push, do_pop;

      assign do_push = push && (cnt_q != CW'(DEPTH));
      assign do_pop  = pop && (cnt_q != '0);

      always_ff @(posedge clk) begin
         if (do_push) mem[wp_q] <= push_data;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
         end
      end

      assign head  = mem[rp_q];
      assign full  = (cnt_q == CW'(DEPTH));
      assign empty = (cnt_q == '0);
      assign count = cnt_q;
   end

   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/sig_slot.sv
module sig_slot #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         take,
   output logic [W-1:0] value,
   output logic         valid
);
   if (W < 1) begin : g_bad_w
      $error("sig_slot: W must be positive");
   end

   logic [W-1:0] val_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              val_q <= '0;
      else if (wr)             val_q <= wdata;
      else if (take && valid)  val_q <= '0;
   end

   assign value = val_q;
   assign valid = (val_q != '0);

   assert_take_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && valid && !wr) |=> !valid);

   assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (value == $past(wdata)));
endmodule

// File: rtl/msgport_unit.sv
module msgport_unit #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned OUT_DEPTH = 1,
   parameter int unsigned IRQ_DEPTH = 1,
   parameter int unsigned IN_DEPTH  = 4,
   parameter int unsigned NSIG      = 2,
   parameter int unsigned ADDR_W    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   out_valid_i,
   input  logic [DATA_W-1:0]      out_data_i,
   output logic                   out_ready_o,
   input  logic                   irqbox_valid_i,
   input  logic [DATA_W-1:0]      irqbox_data_i,
   output logic                   irqbox_ready_o,
   output logic                   in_valid_o,
   output logic [DATA_W-1:0]      in_data_o,
   input  logic                   in_ready_i,
   input  logic [NSIG-1:0]        sig_take_i,
   output logic [NSIG-1:0]        sig_valid_o,
   output logic [NSIG*DATA_W-1:0] sig_data_o,
   input  logic                   mm_wr_i,
   input  logic                   mm_rd_i,
   input  logic [ADDR_W-1:0]      mm_addr_i,
   input  logic [DATA_W-1:0]      mm_wdata_i,
   output logic [DATA_W-1:0]      mm_rdata_o,
   output logic                   irq_o
);
   import msgu_pkg::*;

   localparam int unsigned OCW = $clog2(OUT_DEPTH + 1);
   localparam int unsigned ICW = $clog2(IRQ_DEPTH + 1);
   localparam int unsigned NCW = $clog2(IN_DEPTH + 1);

   if (DATA_W < STAT_OVF_BIT + 1) begin : g_bad_width
      $error("msgport_unit: DATA_W too small for status word");
   end
   if (NSIG < 1 || ADR_SIG_BASE + NSIG > (1 << ADDR_W)) begin : g_bad_map
      $error("msgport_unit: signal registers do not fit address space");
   end

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STATUS);
   localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(ADR_OUT_POP);
   localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(ADR_IRQ_POP);
   localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(ADR_IN_PUSH);

   // Register-port decode
   logic out_pop, irq_pop, in_push, stat_wr;
   assign out_pop = mm_rd_i && (mm_addr_i == A_OUT);
   assign irq_pop = mm_rd_i && (mm_addr_i == A_IRQ);
   assign in_push = mm_wr_i && (mm_addr_i == A_IN);
   assign stat_wr = mm_wr_i && (mm_addr_i == A_STAT);

   // Outbound mailbox
   logic [DATA_W-1:0] out_head;
   logic              out_full, out_empty;
   logic [OCW-1:0]    out_cnt;

   mbox_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_out (
      .clk(clk), .rst_n(rst_n),
      .push(out_valid_i), .push_data(out_data_i), .pop(out_pop),
      .head(out_head), .full(out_full), .empty(out_empty), .count(out_cnt)
   );
   assign out_ready_o = !out_full;

   // Interrupt mailbox
   logic [DATA_W-1:0] irq_head;
   logic              irq_full, irq_empty;
   logic [ICW-1:0]    irq_cnt;

   mbox_fifo #(.W(DATA_W), .DEPTH(IRQ_DEPTH)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .push(irqbox_valid_i), .push_data(irqbox_data_i), .pop(irq_pop),
      .head(irq_head), .full(irq_full), .empty(irq_empty), .count(irq_cnt)
   );
   assign irqbox_ready_o = !irq_full;
   assign irq_o          = !irq_empty;

   // Inbound queue
   logic           in_full, in_empty;
   logic [NCW-1:0] in_cnt;

   mbox_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_in (
      .clk(clk), .rst_n(rst_n),
      .push(in_push), .push_data(mm_wdata_i), .pop(in_ready_i),
      .head(in_data_o), .full(in_full), .empty(in_empty), .count(in_cnt)
   );
   assign in_valid_o = !in_empty;

   // Sticky drop flag
   logic ovf_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                               ovf_q <= 1'b0;
      else if (in_push && in_full)              ovf_q <= 1'b1;
      else if (stat_wr && mm_wdata_i[STAT_OVF_BIT]) ovf_q <= 1'b0;
   end

   // Signal registers
   for (genvar gi = 0; gi < NSIG; gi++) begin : g_sig
      localparam logic [ADDR_W-1:0] A_SIG = ADDR_W'(ADR_SIG_BASE + gi);
      sig_slot #(.W(DATA_W)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .wr(mm_wr_i && (mm_addr_i == A_SIG)), .wdata(mm_wdata_i),
         .take(sig_take_i[gi]),
         .value(sig_data_o[gi*DATA_W +: DATA_W]), .valid(sig_valid_o[gi])
      );
   end

   // Read mux
   logic [DATA_W-1:0] status;
   always_comb begin
      status = '0;
      status[0 +: STAT_FIELD_W]              = STAT_FIELD_W'(out_cnt);
      status[STAT_FIELD_W +: STAT_FIELD_W]   = STAT_FIELD_W'(irq_cnt);
      status[2*STAT_FIELD_W +: STAT_FIELD_W] = STAT_FIELD_W'(in_cnt);
      status[STAT_OVF_BIT]                   = ovf_q;
   end

   always_comb begin
      unique case (mm_addr_i)
         A_STAT:  mm_rdata_o = status;
         A_OUT:   mm_rdata_o = out_empty ? '0 : out_head;
         A_IRQ:   mm_rdata_o = irq_empty ? '0 : irq_head;
         default: mm_rdata_o = '0;
      endcase
   end

   assert_mm_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mm_wr_i && mm_rd_i));

   assert_tx_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_cnt == OCW'(OUT_DEPTH)) |-> !out_ready_o);

   assert_irq_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (irqbox_valid_i && irqbox_ready_o) |=> irq_o);

   assert_rx_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cnt == '0) |-> !in_valid_o);

   assert_drop_sets_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_push && in_full) |=> status[STAT_OVF_BIT]);

   assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !stat_wr) |=> ovf_q);
endmodule

// File: tb/tb_msgport_unit.sv
module tb_msgport_unit;
   localparam int W = 32;
   localparam int NS = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic out_valid = 0, irqbox_valid = 0, in_ready = 0, mm_wr = 0, mm_rd = 0;
   logic [W-1:0] out_data = '0, irqbox_data = '0, mm_wdata = '0;
   logic [2:0] mm_addr = '0;
   logic [NS-1:0] sig_take = '0;
   logic out_ready, irqbox_ready, in_valid, irq;
   logic [W-1:0] in_data, mm_rdata;
   logic [NS-1:0] sig_valid;
   logic [NS*W-1:0] sig_data;

   msgport_unit dut (
      .clk(clk), .rst_n(rst_n),
      .out_valid_i(out_valid), .out_data_i(out_data), .out_ready_o(out_ready),
      .irqbox_valid_i(irqbox_valid), .irqbox_data_i(irqbox_data), .irqbox_ready_o(irqbox_ready),
      .in_valid_o(in_valid), .in_data_o(in_data), .in_ready_i(in_ready),
      .sig_take_i(sig_take), .sig_valid_o(sig_valid), .sig_data_o(sig_data),
      .mm_wr_i(mm_wr), .mm_rd_i(mm_rd), .mm_addr_i(mm_addr), .mm_wdata_i(mm_wdata),
      .mm_rdata_o(mm_rdata), .irq_o(irq)
   );

   always #2.5 clk = ~clk;

   int checks = 0, failures = 0;
   bit done = 0;

   logic [W-1:0] q_out[$], q_irq[$], q_in[$];
   logic [W-1:0] sig_m [NS];
   bit ovf_m = 0;

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] exp_status();
      logic [W-1:0] s = '0;
      s[7:0]   = 8'(q_out.size());
      s[15:8]  = 8'(q_irq.size());
      s[23:16] = 8'(q_in.size());
      s[31]    = ovf_m;
      return s;
   endfunction

   // All tasks start and end at a falling edge.
   task automatic cpu_send(input int box, input logic [W-1:0] d);
      if (box == 0) begin out_valid = 1; out_data = d; end
      else begin irqbox_valid = 1; irqbox_data = d; end
      while (!(box == 0 ? out_ready : irqbox_ready)) @(negedge clk);
      @(negedge clk);
      out_valid = 0; irqbox_valid = 0;
   endtask

   task automatic mm_read(input int a, output logic [W-1:0] d);
      mm_rd = 1; mm_addr = 3'(a);
      #1 d = mm_rdata;
      @(negedge clk);
      mm_rd = 0;
   endtask

   task automatic mm_write(input int a, input logic [W-1:0] d);
      mm_wr = 1; mm_addr = 3'(a); mm_wdata = d;
      @(negedge clk);
      mm_wr = 0;
   endtask

   task automatic cpu_rx(output logic [W-1:0] d);
      in_ready = 1;
      while (!in_valid) @(negedge clk);
      d = in_data;
      @(negedge clk);
      in_ready = 0;
   endtask

   task automatic cpu_sig(input int i, output logic [W-1:0] d);
      sig_take[i] = 1;
      while (!sig_valid[i]) @(negedge clk);
      d = sig_data[i*W +: W];
      @(negedge clk);
      sig_take[i] = 0;
   endtask

   initial begin
      #(150000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] d, v;
      void'($urandom(32'h5eed_c0de));
      for (int i = 0; i < NS; i++) sig_m[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R8 reset state
      check("R8 irq", W'(irq), 0);
      check("R8 in_valid", W'(in_valid), 0);
      check("R8 sig_valid", W'(sig_valid), 0);
      check("R8 ready", W'({out_ready, irqbox_ready}), 3);
      mm_read(0, d); check("R8 status", d, 0);

      // R1 stall on full outbound mailbox, read empty returns 0
      mm_read(1, d); check("R1 empty read", d, 0);
      cpu_send(0, 32'hAAAA_0001);
      check("R1 full", W'(out_ready), 0);
      fork
         cpu_send(0, 32'hAAAA_0002);
         begin
            repeat (3) @(negedge clk);
            check("R1 stalled", W'(out_ready), 0);
            mm_read(1, d); check("R1 first", d, 32'hAAAA_0001);
         end
      join
      mm_read(1, d); check("R1 second", d, 32'hAAAA_0002);
      mm_read(0, d); check("R1 drained status", d, 0);

      // R2 interrupt mailbox
      cpu_send(1, 32'h1234_5678);
      check("R2 irq high", W'(irq), 1);
      mm_read(0, d); check("R7 status irq count", d, 32'h0000_0100);
      mm_read(2, d); check("R2 data", d, 32'h1234_5678);
      check("R2 irq low", W'(irq), 0);

      // R3 stall on empty inbound
      fork
         cpu_rx(v);
         begin
            repeat (4) @(negedge clk);
            check("R3 empty stalls", W'(in_valid), 0);
            mm_write(3, 32'hBEEF_0000);
         end
      join
      check("R3 delivered", v, 32'hBEEF_0000);

      // R4 overflow drop
      for (int k = 0; k < 5; k++) mm_write(3, 32'hC000_0000 + W'(k));
      mm_read(0, d); check("R4 status ovf", d, 32'h8004_0000);
      for (int k = 0; k < 4; k++) begin
         cpu_rx(v); check("R3 order", v, 32'hC000_0000 + W'(k));
      end
      check("R4 dropped", W'(in_valid), 0);
      mm_read(0, d); check("R4 sticky", d, 32'h8000_0000);
      mm_write(0, 32'h8000_0000);
      mm_read(0, d); check("R4 cleared", d, 0);

      // R5 signal clear on take
      mm_write(4, 32'h0000_00F0);
      check("R5 valid", W'(sig_valid), 1);
      cpu_sig(0, v); check("R5 value", v, 32'h0000_00F0);
      check("R5 cleared", W'(sig_valid), 0);

      // R6 write and take in one cycle
      mm_write(5, 32'h0000_0011);
      fork
         cpu_sig(1, v);
         mm_write(5, 32'h0000_0022);
      join
      check("R6 old value taken", v, 32'h0000_0011);
      check("R6 kept valid", W'(sig_valid[1]), 1);
      cpu_sig(1, v); check("R6 new value", v, 32'h0000_0022);

      // Random mix against model
      for (int it = 0; it < 600; it++) begin
         int op = int'($urandom_range(0, 9));
         int si = int'($urandom_range(0, NS - 1));
         logic [W-1:0] rv = $urandom;
         case (op)
            0: if (q_out.size() < 1) begin cpu_send(0, rv); q_out.push_back(rv); end
               else check("R1 ready low", W'(out_ready), 0);
            1: begin
                  if (q_irq.size() < 1) begin cpu_send(1, rv); q_irq.push_back(rv); end
                  else check("R2 ready low", W'(irqbox_ready), 0);
                  check("R2 irq", W'(irq), 1);
               end
            2: begin
                  mm_read(1, d);
                  check("R1 read", d, q_out.size() ? q_out[0] : '0);
                  if (q_out.size()) void'(q_out.pop_front());
               end
            3: begin
                  mm_read(2, d);
                  check("R2 read", d, q_irq.size() ? q_irq[0] : '0);
                  if (q_irq.size()) void'(q_irq.pop_front());
                  check("R2 irq after read", W'(irq), W'(q_irq.size() != 0));
               end
            4: begin
                  mm_write(3, rv);
                  if (q_in.size() < 4) q_in.push_back(rv); else ovf_m = 1;
               end
            5: if (q_in.size()) begin
                  cpu_rx(v); check("R3 rx", v, q_in.pop_front());
               end else check("R3 rx empty", W'(in_valid), 0);
            6: begin
                  if (rv[1:0] == 0) rv = '0;
                  mm_write(4 + si, rv); sig_m[si] = rv;
               end
            7: if (sig_m[si] != 0) begin
                  cpu_sig(si, v); check("R5 sig", v, sig_m[si]); sig_m[si] = '0;
               end else check("R5 sig zero", W'(sig_valid[si]), 0);
            8: begin mm_read(0, d); check("R7 status", d, exp_status()); end
            default: begin
                  mm_write(0, {rv[0], 31'h0});
                  if (rv[0]) ovf_m = 0;
               end
         endcase
      end
      mm_read(0, d); check("R7 final status", d, exp_status());
      mm_read(6, d); check("R7 unmapped", d, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule